// File: doc/BRIEF.md
# Four-Digit Multiplexed Stopwatch

This block counts elapsed milliseconds on four cascaded digit counters and presents the count on one shared seven-segment display, which is driven one digit at a time. A small controller decides whether the count advances: a start/stop pulse toggles between running and halted, and a clear pulse returns everything to zero and idle. At build time a parameter chooses between decimal digits (each rolls over after 9) and hexadecimal digits (each rolls over after F). In decimal mode the top digit then steps once per second.

The display scan, the millisecond tick and the blink rate all come from prescalers whose ratios are parameters. The defaults give about 1 kHz per digit slot and a blink period of about 250 ms from a 50 MHz clock. Setting `CLK_KHZ` to 100000 retargets the same ratios to a 100 MHz clock. The blink is a warning. While the most significant digit reads 9 or more, every segment goes dark during the off half of the blink cycle. The count itself keeps going. The control inputs are plain single-cycle pulses and must already be debounced. There is no data stream, so the block has no valid/ready handshake.

Top module: `stopwatch_mux`

## Requirements
- R1: While the controller is running, the count rises by one each `TICK_DIV` clock edges. The prescaler phase is kept while halted and set to zero by clear or reset.
- R2: Each digit counts from 0 up to its maximum: 9 when `HEX_MODE`=0, 15 when `HEX_MODE`=1. On the step after its maximum it returns to 0 and carries one into the next digit. When all digits are at their maximum, the whole count wraps to zero.
- R3: The states are idle, running and halted. A start_stop pulse moves idle to running, running to halted and halted to running. While idle or halted the count does not change.
- R4: A clear pulse in any state zeroes all digits and the prescaler and enters idle on the next edge. If start_stop arrives in the same cycle, clear takes priority.
- R5: An asynchronous active-low reset gives: count zero, idle, scan slot 0, blink phase lit.
- R6: Exactly one bit of `dig_en_n` is low at any time. The slot advances every `SCAN_DIV` clock edges in the order 0,1,..,NDIG-1 and then back to 0. Slot k drives `dig_en_n[k]` low and shows digit k, where digit 0 is the least significant.
- R7: `seg` is active-high with bit 0 = segment a through bit 6 = segment g. The patterns for digits 0..F are 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71 (hex).
- R8: With `BLINK_EN`=1 and the top digit at 9 or more, `seg` is all zero during the off phase. The phase toggles every `BLINK_HALF` clock edges, runs freely from reset and starts lit. Counting continues during the blink.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_stop | input | 1 | Single-cycle pulse that toggles running and halted |
| clear | input | 1 | Single-cycle pulse that zeroes the count and enters idle |
| seg | output | 7 | Segment lines a..g, active high |
| dig_en_n | output | NDIG | Digit enables, active low, one at a time |

## Verification
A digit register stuck or mis-carrying shows up as a wrong segment pattern the next time its scan slot comes round, so within NDIG·SCAN_DIV clocks. A prescaler or controller fault shifts the count, and the shift becomes visible by the following tick. A wrong scan slot corrupts `dig_en_n` on the very clock it happens. A wrong blink phase or threshold shows up as dark or lit segments in the wrong half-period. The bench runs its own integer model of count, slot and blink phase next to both a decimal and a hexadecimal build. It compares the ports on every clock and runs long enough to see full wraps in both builds.

// File: rtl/sw_pkg.sv
package sw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HALT = 2'd2
  } sw_state_e;

  // Segment image of one digit, bit0 = a ... bit6 = g, active high.
  function automatic logic [6:0] seg_encode(input logic [3:0] v);
    logic [6:0] s;
    case (v)
      4'h0: s = 7'h3F;
      4'h1: s = 7'h06;
      4'h2: s = 7'h5B;
      4'h3: s = 7'h4F;
      4'h4: s = 7'h66;
      4'h5: s = 7'h6D;
      4'h6: s = 7'h7D;
      4'h7: s = 7'h07;
      4'h8: s = 7'h7F;
      4'h9: s = 7'h6F;
      4'hA: s = 7'h77;
      4'hB: s = 7'h7C;
      4'hC: s = 7'h39;
      4'hD: s = 7'h5E;
      4'hE: s = 7'h79;
      default: s = 7'h71;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/sw_prescaler.sv
module sw_prescaler #(
  parameter int DIV = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (en) begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end

  assign tick = en && (cnt == LAST);

  generate
    if (DIV > 1) begin : g_spacing
      // R1: ticks are at least DIV edges apart, never back to back
      p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/sw_digit.sv
module sw_digit #(
  parameter int MAXV = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       inc,
  output logic [3:0] q,
  output logic       carry
);
  localparam logic [3:0] TOP = 4'(MAXV);

  logic at_max;
  assign at_max = (q == TOP);
  assign carry  = inc && at_max;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (inc) q <= at_max ? 4'd0 : q + 4'd1;
  end

  p_digit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    q <= TOP);
  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    carry |=> (q == 4'd0));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(q));
endmodule

// File: rtl/sw_ctrl.sv
module sw_ctrl
  import sw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_stop,
  input  logic      clear,
  output sw_state_e state,
  output logic      run
);
  sw_state_e nxt;

  always_comb begin
    nxt = state;
    if (clear) nxt = ST_IDLE;
    else if (start_stop) begin
      case (state)
        ST_RUN:  nxt = ST_HALT;
        default: nxt = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign run = (state == ST_RUN);

  p_clear_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (state == ST_IDLE));
  p_toggle_halt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_stop && !clear && state == ST_RUN) |=> (state == ST_HALT));
  p_legal_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'd3);
endmodule

// File: rtl/sw_scan.sv
module sw_scan
  import sw_pkg::*;
#(
  parameter int NDIG       = 4,
  parameter int SCAN_DIV   = 50000,
  parameter int BLINK_HALF = 6250000,
  parameter bit BLINK_EN   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NDIG-1:0][3:0] digits,
  input  logic                 warn,
  output logic [6:0]           seg,
  output logic [NDIG-1:0]      dig_en_n
);
  localparam int SW = (NDIG > 1) ? $clog2(NDIG) : 1;
  localparam int CW = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
  localparam logic [SW-1:0] SLOT_LAST = SW'(NDIG - 1);
  localparam logic [CW-1:0] SCAN_LAST = CW'(SCAN_DIV - 1);

  logic [SW-1:0] slot;
  logic [CW-1:0] scnt;
  logic          lit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt <= '0;
      slot <= '0;
    end else if (scnt == SCAN_LAST) begin
      scnt <= '0;
      slot <= (slot == SLOT_LAST) ? '0 : slot + 1'b1;
    end else begin
      scnt <= scnt + 1'b1;
    end
  end

  generate
    if (BLINK_EN) begin : g_blink
      localparam int BW = (BLINK_HALF > 1) ? $clog2(BLINK_HALF) : 1;
      localparam logic [BW-1:0] B_LAST = BW'(BLINK_HALF - 1);
      logic [BW-1:0] bcnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bcnt <= '0;
          lit  <= 1'b1;
        end else if (bcnt == B_LAST) begin
          bcnt <= '0;
          lit  <= ~lit;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end
    end else begin : g_steady
      assign lit = 1'b1;
    end
  endgenerate

  always_comb begin
    dig_en_n = '1;
    dig_en_n[slot] = 1'b0;
    seg = (warn && !lit) ? 7'h00 : seg_encode(digits[slot]);
  end

  p_one_digit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~dig_en_n) == 1);
  p_slot_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (scnt != SCAN_LAST) |=> $stable(dig_en_n));
  p_blank_only_warn_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == 7'h00) |-> warn);
endmodule

// File: rtl/stopwatch_mux.sv
module stopwatch_mux
  import sw_pkg::*;
#(
  parameter int CLK_KHZ    = 50000,
  parameter int TICK_DIV   = CLK_KHZ,
  parameter int SCAN_DIV   = CLK_KHZ,
  parameter int BLINK_HALF = CLK_KHZ * 125,
  parameter bit HEX_MODE   = 1'b0,
  parameter bit BLINK_EN   = 1'b1,
  parameter int NDIG       = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_stop,
  input  logic            clear,
  output logic [6:0]      seg,
  output logic [NDIG-1:0] dig_en_n
);
  localparam int         MAXV    = HEX_MODE ? 15 : 9;
  localparam logic [3:0] WARN_AT = 4'd9;

  sw_state_e             state;
  logic                  run;
  logic                  tick;
  logic [NDIG:0]         inc;
  logic [NDIG-1:0][3:0]  digits;
  logic                  warn;

  sw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_stop(start_stop), .clear(clear),
    .state(state), .run(run)
  );

  sw_prescaler #(.DIV(TICK_DIV)) u_ms (
    .clk(clk), .rst_n(rst_n), .clr(clear), .en(run), .tick(tick)
  );

  assign inc[0] = tick;

  generate
    for (genvar i = 0; i < NDIG; i++) begin : g_dig
      sw_digit #(.MAXV(MAXV)) u_d (
        .clk(clk), .rst_n(rst_n), .clr(clear), .inc(inc[i]),
        .q(digits[i]), .carry(inc[i+1])
      );
    end
  endgenerate

  assign warn = (digits[NDIG-1] >= WARN_AT);

  sw_scan #(
    .NDIG(NDIG), .SCAN_DIV(SCAN_DIV), .BLINK_HALF(BLINK_HALF), .BLINK_EN(BLINK_EN)
  ) u_scan (
    .clk(clk), .rst_n(rst_n), .digits(digits), .warn(warn),
    .seg(seg), .dig_en_n(dig_en_n)
  );

  // R1: no digit moves unless the controller was running
  p_count_needs_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clear) |=> $stable(digits));
  // R4: clear leaves every digit at zero
  p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (digits == '0));
endmodule

// File: tb/stopwatch_mux_test.sv
module sw_ref #(
  parameter int BASE  = 10,
  parameter int TICK  = 4,
  parameter int SCAN  = 3,
  parameter int BHALF = 50,
  parameter bit BLINK = 1'b1,
  parameter int NDIG  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ss,
  input  logic            clr,
  output logic [6:0]      exp_seg,
  output logic [NDIG-1:0] exp_en,
  output int              count,
  output bit              blanked
);
  int st, pre, slot, scnt, bcnt;
  bit lit;

  function automatic int ipow(input int b, input int e);
    int r = 1;
    for (int i = 0; i < e; i++) r = r * b;
    return r;
  endfunction

  function automatic logic [6:0] seg_of(input int d);
    logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                           7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return t[d];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st = 0; pre = 0; count = 0; slot = 0; scnt = 0; bcnt = 0; lit = 1;
    end else begin
      if (st == 1) begin
        pre = pre + 1;
        if (pre == TICK) begin
          pre = 0;
          count = (count + 1) % ipow(BASE, NDIG);
        end
      end
      if (clr) begin
        st = 0; pre = 0; count = 0;
      end else if (ss) begin
        st = (st == 1) ? 2 : 1;
      end
      scnt = scnt + 1;
      if (scnt == SCAN) begin
        scnt = 0;
        slot = (slot + 1) % NDIG;
      end
      if (BLINK) begin
        bcnt = bcnt + 1;
        if (bcnt == BHALF) begin
          bcnt = 0;
          lit = !lit;
        end
      end
    end
  end

  always @* begin
    int d, top;
    d   = (count / ipow(BASE, slot)) % BASE;
    top = (count / ipow(BASE, NDIG - 1)) % BASE;
    blanked = BLINK && (top >= 9) && !lit;
    exp_seg = blanked ? 7'h00 : seg_of(d);
    exp_en  = '1;
    exp_en[slot] = 1'b0;
  end
endmodule

module stopwatch_mux_test;
  localparam int NDIG = 4;
  localparam int SCAN = 3;
  localparam int BH   = 50;

  logic clk = 0;
  logic rst_n = 0;
  logic start_stop = 0;
  logic clear = 0;
  logic [6:0]      seg_d, seg_h, eseg_d, eseg_h;
  logic [NDIG-1:0] en_d, en_h, een_d, een_h;
  int cnt_d, cnt_h;
  bit blk_d, blk_h;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stopwatch_mux #(.TICK_DIV(4), .SCAN_DIV(SCAN), .BLINK_HALF(BH),
                  .HEX_MODE(1'b0), .BLINK_EN(1'b1), .NDIG(NDIG)) uut (
    .clk(clk), .rst_n(rst_n), .start_stop(start_stop), .clear(clear),
    .seg(seg_d), .dig_en_n(en_d));

  stopwatch_mux #(.TICK_DIV(2), .SCAN_DIV(SCAN), .BLINK_HALF(BH),
                  .HEX_MODE(1'b1), .BLINK_EN(1'b1), .NDIG(NDIG)) uut_hex (
    .clk(clk), .rst_n(rst_n), .start_stop(start_stop), .clear(clear),
    .seg(seg_h), .dig_en_n(en_h));

  sw_ref #(.BASE(10), .TICK(4), .SCAN(SCAN), .BHALF(BH), .BLINK(1'b1), .NDIG(NDIG)) ref_d (
    .clk(clk), .rst_n(rst_n), .ss(start_stop), .clr(clear),
    .exp_seg(eseg_d), .exp_en(een_d), .count(cnt_d), .blanked(blk_d));

  sw_ref #(.BASE(16), .TICK(2), .SCAN(SCAN), .BHALF(BH), .BLINK(1'b1), .NDIG(NDIG)) ref_h (
    .clk(clk), .rst_n(rst_n), .ss(start_stop), .clr(clear),
    .exp_seg(eseg_h), .exp_en(een_h), .count(cnt_h), .blanked(blk_h));

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-clock comparison of both builds against the models
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cycles++;
      check("R6 dec digit enable", en_d, een_d);
      check(blk_d ? "R8 dec blink" : "R2 R7 dec segments", seg_d, eseg_d);
      check("R6 hex digit enable", en_h, een_h);
      check(blk_h ? "R8 hex blink" : "R2 R7 hex segments", seg_h, eseg_h);
    end
  end

  // read all digits of one build from the port scan
  task automatic read_disp(input bit hex, output int val);
    int base = hex ? 16 : 10;
    int mul = 1;
    val = 0;
    for (int k = 0; k < NDIG; k++) begin
      logic [NDIG-1:0] want;
      int dg;
      want = '1;
      want[k] = 1'b0;
      do @(negedge clk); while ((hex ? en_h : en_d) !== want);
      dg = -1;
      for (int i = 0; i < 16; i++)
        if (ref_d.seg_of(i) == (hex ? seg_h : seg_d)) dg = i;
      val = val + dg * mul;
      mul = mul * base;
    end
  endtask

  task automatic pulse(input bit ss, input bit cl);
    @(negedge clk);
    start_stop = ss;
    clear = cl;
    @(negedge clk);
    start_stop = 0;
    clear = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    wait (cycles > 190000);
    checks++;
    errors++;
    $display("FAIL watchdog: got %0d cycles expected completion", cycles);
    finish_run();
  end

  initial begin
    int v1, v2;
    #1;
    // R5: reset state
    check("R5 reset enables", en_d, 4'b1110);
    check("R5 reset segments", seg_d, 7'h3F);
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    check("R5 after release", seg_h, 7'h3F);

    // R3: idle holds zero
    wait_cyc(40);
    read_disp(0, v1);
    check("R3 idle holds zero", v1, 0);

    // R1 R3: run, halt, and hold
    pulse(1, 0);
    wait_cyc(203);
    pulse(1, 0);
    read_disp(0, v1);
    check("R1 dec count after run", v1, cnt_d);
    read_disp(1, v2);
    check("R1 hex count after run", v2, cnt_h);
    wait_cyc(150);
    read_disp(0, v2);
    check("R3 halted count stable", v2, v1);

    // resume from halt keeps the prescaler phase
    pulse(1, 0);
    wait_cyc(77);
    pulse(1, 0);
    read_disp(0, v1);
    check("R1 resume count", v1, cnt_d);

    // R4: clear together with start_stop
    pulse(1, 0);
    wait_cyc(60);
    pulse(1, 1);
    read_disp(0, v1);
    check("R4 clear wins to zero", v1, 0);
    wait_cyc(30);
    read_disp(1, v2);
    check("R4 stays idle after clear", v2, 0);

    // long run: decimal wraps several times, hex reaches F-range and wraps
    pulse(1, 0);
    wait_cyc(36100);
    checks++;
    if (cnt_d < 9000) begin
      errors++;
      $display("FAIL R8 setup: got %0d expected >= 9000", cnt_d);
    end
    wait_cyc(95500);
    checks++;
    if (cnt_h > 1000) begin
      errors++;
      $display("FAIL R2 hex wrap: got %0d expected small", cnt_h);
    end
    pulse(1, 0);
    read_disp(1, v2);
    check("R2 hex after wrap", v2, cnt_h);

    finish_run();
  end
endmodule